// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between a memory scheduler and the command pins of a four-bank synchronous DRAM. The scheduler offers one abstract command at a time: mode set, activate, read, write, single-bank precharge, all-bank precharge, refresh or burst stop. Each command comes with a bank number and an address word. The gate checks the command against the state of the target bank and of the whole device. It holds the command (ready low) until every minimum spacing is met, then encodes it onto the strobe, bank and address pins for one clock. On every other cycle it drives a no-operation.

The gate keeps, for each bank, whether a row is open and whether a self-closing (auto-precharge) burst is in flight. Each bank has its own down-counters for column access after activate, minimum row-active time, row cycle, precharge recovery and write recovery. Device-wide counters space activates across banks, quieten the bus after mode set and refresh, and block column commands while an auto-precharge burst runs. A command that makes no sense in the current state is refused at once instead of being held. Such commands are a column access to a closed bank, an activate to an open bank, and a mode set or refresh while a row is open. Burst address generation and refresh scheduling belong to the scheduler.

All limits are parameters: timings are given in picoseconds and rounded up to whole clocks. The defaults (10 ns clock) give activate-to-column 2, row-active 5, row cycle 7, precharge 2, activate-to-activate 2, write recovery 2, mode-set gap 2 and burst length 4 clocks.

Top module: `sdc_cmd_timer`

## Requirements
- R1: Pins (cs_n, ras_n, cas_n, we_n) carry 0000 mode set, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0010 precharge (single or all), 0110 burst stop and 0111 no-op. An accepted command appears on the pins in the clock after its accepting edge. The pins show no-op on every cycle in which nothing was accepted, including stalled ones.
- R2: Command codes on cmd_op are 0 mode set, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh and 7 burst stop. Activate drives the 13-bit row from cmd_addr; mode set drives cmd_addr unchanged. Read and write drive cmd_addr[9:0] as the column, with address bit 10 copied from cmd_addr[10] as the auto-precharge request and bits 12:11 zero. Precharge drives address 0, precharge-all drives only bit 10 high. The bank pins carry cmd_bank for mode set, activate, read, write and precharge.
- R3: A read or write to a bank is accepted no sooner than RCD clocks (2) after that bank's activate; while it waits, ready is low.
- R4: Activates to different banks are at least RRD clocks (2) apart. Activates to the same bank are at least RC clocks (7) apart.
- R5: A precharge of an open bank follows its activate by at least RAS clocks (5). An activate follows the bank's precharge by at least RP clocks (2).
- R6: After a write, precharge of that bank waits BL-1+WR clocks (5) from the write command.
- R7: A read with auto-precharge blocks all reads and writes for BL clocks (4), and its bank reopens no sooner than BL+RP clocks (6) after it. A write with auto-precharge lets its bank reopen no sooner than BL-1+WR+RP clocks (7).
- R8: Mode set and refresh wait until every bank is closed and precharge recovery is done. Any command after a mode set waits MRD clocks (2); any command after a refresh waits RC clocks (7).
- R9: Some commands are refused with cmd_reject high, ready high and no-op on the pins. These are a read or write to a closed or self-closing bank, an activate to an open bank, and a mode set or refresh while any bank has an open row.
- R10: Precharge-all waits for every bank's row-active and write-recovery limits and then closes all banks.
- R11: After reset the pins show no-op, all banks are closed and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_addr | input | 13 | Row, column/auto-precharge or mode word |
| cmd_ready | output | 1 | Offered command is taken at the next edge |
| cmd_reject | output | 1 | Offered command is illegal and is dropped |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select pins |
| sd_addr | output | 13 | Multiplexed address pins |

## Verification
The bench goes after exact acceptance edges: a counter loaded one clock too short would let a read land one cycle after its activate, or let a precharge cut a row before its active time. The two auto-precharge flavours are timed separately, because a design that closes a written bank at the end of the burst instead of after write recovery reopens it two clocks early. Precharge-all is followed directly by a mode set; a gate that forgot to close every bank would refuse that mode set. Illegal commands are checked for an immediate refusal with no pins toggled, since a design that stalled them instead would hang the scheduler.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    OP_MRS  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_BST  = 3'd7
  } sdc_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdc_pins_t;

  localparam sdc_pins_t PINS_NOP = 4'b0111;

  // Round a time in picoseconds up to whole clocks, never below one.
  function automatic int ps_to_clk(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // A minimum gap of t edges is held by a counter loaded with t-1.
  function automatic int gap_load(input int t);
    return (t > 0) ? t - 1 : 0;
  endfunction

  // Edges from a column command to the internal close of its bank.
  function automatic int ap_wait(input bit is_write, input int bl, input int wr);
    return is_write ? (bl - 1 + wr) : bl;
  endfunction

  function automatic sdc_pins_t encode(input sdc_op_e op);
    case (op)
      OP_MRS:          return 4'b0000;
      OP_REF:          return 4'b0001;
      OP_ACT:          return 4'b0011;
      OP_RD:           return 4'b0101;
      OP_WR:           return 4'b0100;
      OP_PRE, OP_PREA: return 4'b0010;
      OP_BST:          return 4'b0110;
      default:         return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdc_bank_ctl.sv
module sdc_bank_ctl #(
  parameter int RCD = 2,
  parameter int RAS = 5,
  parameter int RC  = 7,
  parameter int RP  = 2,
  parameter int BL  = 4,
  parameter int WR  = 2,
  parameter int CW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic col_i,
  input  logic col_wr_i,
  input  logic col_ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic closing_o,
  output logic act_ok_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic idle_o
);
  import sdc_pkg::*;

  localparam logic [CW-1:0] LD_RCD   = CW'(gap_load(RCD));
  localparam logic [CW-1:0] LD_RAS   = CW'(gap_load(RAS));
  localparam logic [CW-1:0] LD_RC    = CW'(gap_load(RC));
  localparam logic [CW-1:0] LD_RP    = CW'(gap_load(RP));
  localparam logic [CW-1:0] LD_WREC  = CW'(gap_load(BL - 1 + WR));
  localparam logic [CW-1:0] LD_AP_RD = CW'(gap_load(ap_wait(1'b0, BL, WR)));
  localparam logic [CW-1:0] LD_AP_WR = CW'(gap_load(ap_wait(1'b1, BL, WR)));

  logic          open_q, closing_q;
  logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q, ap_q;
  logic          ap_fire;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c);
    return (c != '0) ? c - 1'b1 : c;
  endfunction

  // Internal close of a self-closing bank: burst done and row time met.
  assign ap_fire = closing_q && (ap_q == '0) && (ras_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
      rcd_q     <= '0;
      ras_q     <= '0;
      rc_q      <= '0;
      rp_q      <= '0;
      wr_q      <= '0;
      ap_q      <= '0;
    end else begin
      rcd_q <= step(rcd_q);
      ras_q <= step(ras_q);
      rc_q  <= step(rc_q);
      rp_q  <= step(rp_q);
      wr_q  <= step(wr_q);
      ap_q  <= step(ap_q);
      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= LD_RCD;
        ras_q  <= LD_RAS;
        rc_q   <= LD_RC;
      end
      if (col_i) begin
        if (col_wr_i) wr_q <= LD_WREC;
        if (col_ap_i) begin
          closing_q <= 1'b1;
          ap_q      <= col_wr_i ? LD_AP_WR : LD_AP_RD;
        end
      end
      if ((pre_i && open_q) || ap_fire) begin
        open_q    <= 1'b0;
        closing_q <= 1'b0;
        rp_q      <= LD_RP;
      end
    end
  end

  assign open_o    = open_q;
  assign closing_o = closing_q;
  assign act_ok_o  = !open_q && (rp_q == '0) && (rc_q == '0);
  assign col_ok_o  = open_q && !closing_q && (rcd_q == '0);
  assign pre_ok_o  = !open_q || (!closing_q && (ras_q == '0) && (wr_q == '0));
  assign idle_o    = !open_q && (rp_q == '0);

  AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (open_q && !closing_q && rcd_q == '0)); // R3
  AST_ACT_AFTER_RP_RC: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0 && rc_q == '0)); // R5
  AST_PRE_AFTER_RAS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (ras_q == '0 && wr_q == '0)); // R6
  AST_AP_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (closing_q && ap_q == '0 && ras_q == '0) |=> (!open_q && rp_q == LD_RP)); // R7

endmodule

// File: rtl/sdc_dev_ctl.sv
module sdc_dev_ctl #(
  parameter int RRD = 2,
  parameter int MRD = 2,
  parameter int RFC = 7,
  parameter int BL  = 4,
  parameter int CW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic act_i,
  input  logic col_i,
  input  logic col_ap_i,
  input  logic mrs_i,
  input  logic ref_i,
  output logic rrd_ok_o,
  output logic col_free_o,
  output logic quiet_ok_o
);
  import sdc_pkg::*;

  localparam logic [CW-1:0] LD_RRD = CW'(gap_load(RRD));
  localparam logic [CW-1:0] LD_MRD = CW'(gap_load(MRD));
  localparam logic [CW-1:0] LD_RFC = CW'(gap_load(RFC));
  localparam logic [CW-1:0] LD_APB = CW'(gap_load(BL));

  logic [CW-1:0] rrd_q, quiet_q, apb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q   <= '0;
      quiet_q <= '0;
      apb_q   <= '0;
    end else begin
      rrd_q   <= (rrd_q   != '0) ? rrd_q   - 1'b1 : rrd_q;
      quiet_q <= (quiet_q != '0) ? quiet_q - 1'b1 : quiet_q;
      apb_q   <= (apb_q   != '0) ? apb_q   - 1'b1 : apb_q;
      if (act_i)             rrd_q   <= LD_RRD;
      if (mrs_i)             quiet_q <= LD_MRD;
      if (ref_i)             quiet_q <= LD_RFC;
      if (col_i && col_ap_i) apb_q   <= LD_APB;
    end
  end

  assign rrd_ok_o   = (rrd_q == '0);
  assign col_free_o = (apb_q == '0);
  assign quiet_ok_o = (quiet_q == '0);

  AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (rrd_q == '0)); // R4
  AST_QUIET_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (quiet_q == '0)); // R8
  AST_AP_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (apb_q == '0)); // R7

endmodule

// File: rtl/sdc_pin_drv.sv
module sdc_pin_drv #(
  parameter int AW     = 13,
  parameter int COLW   = 10,
  parameter int AP_BIT = 10,
  parameter int BAW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  sdc_pkg::sdc_op_e  op_i,
  input  logic [BAW-1:0]    bank_i,
  input  logic [AW-1:0]     addr_i,
  output sdc_pkg::sdc_pins_t pins_o,
  output logic [BAW-1:0]    ba_o,
  output logic [AW-1:0]     addr_o
);
  import sdc_pkg::*;

  logic [AW-1:0]  nxt_addr;
  logic [BAW-1:0] nxt_ba;

  always_comb begin
    nxt_addr = '0;
    nxt_ba   = '0;
    case (op_i)
      OP_ACT, OP_MRS: begin
        nxt_addr = addr_i;
        nxt_ba   = bank_i;
      end
      OP_RD, OP_WR: begin
        nxt_addr[COLW-1:0] = addr_i[COLW-1:0];
        nxt_addr[AP_BIT]   = addr_i[AP_BIT];
        nxt_ba             = bank_i;
      end
      OP_PRE:  nxt_ba = bank_i;
      OP_PREA: nxt_addr[AP_BIT] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_o <= PINS_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end else if (issue_i) begin
      pins_o <= encode(op_i);
      ba_o   <= nxt_ba;
      addr_o <= nxt_addr;
    end else begin
      pins_o <= PINS_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end
  end

  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (pins_o == PINS_NOP)); // R1

endmodule

// File: rtl/sdc_cmd_timer.sv
module sdc_cmd_timer #(
  parameter int CLK_PS    = 10000,
  parameter int T_RCD_PS  = 20000,
  parameter int T_RAS_PS  = 50000,
  parameter int T_RC_PS   = 70000,
  parameter int T_RP_PS   = 20000,
  parameter int T_RRD_PS  = 20000,
  parameter int WR_CK     = 2,
  parameter int MRD_CK    = 2,
  parameter int BURST_LEN = 4,
  parameter int NB        = 4,
  parameter int AW        = 13,
  parameter int COLW      = 10,
  parameter int AP_BIT    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [$clog2(NB)-1:0] cmd_bank,
  input  logic [AW-1:0]         cmd_addr,
  output logic                  cmd_ready,
  output logic                  cmd_reject,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [$clog2(NB)-1:0] sd_ba,
  output logic [AW-1:0]         sd_addr
);
  import sdc_pkg::*;

  localparam int BAW   = $clog2(NB);
  localparam int RCD_C = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int RAS_C = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int RC_C  = ps_to_clk(T_RC_PS,  CLK_PS);
  localparam int RP_C  = ps_to_clk(T_RP_PS,  CLK_PS);
  localparam int RRD_C = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int CW    = $clog2(RC_C + RAS_C + BURST_LEN + WR_CK + MRD_CK + 1);

  sdc_op_e       op;
  logic [NB-1:0] is_open, closing, act_ok, col_ok, pre_ok, idle, live;
  logic [NB-1:0] bank_act, bank_col, bank_pre;
  logic          legal, tim_ok, issue;
  logic          rrd_ok, col_free, quiet_ok;
  logic          is_col;
  sdc_pins_t     pins;

  assign op     = sdc_op_e'(cmd_op);
  assign live   = is_open & ~closing;
  assign is_col = (op == OP_RD) || (op == OP_WR);

  always_comb begin
    case (op)
      OP_ACT:         legal = !live[cmd_bank];
      OP_RD, OP_WR:   legal = live[cmd_bank];
      OP_MRS, OP_REF: legal = (live == '0);
      default:        legal = 1'b1;
    endcase
  end

  always_comb begin
    case (op)
      OP_ACT:         tim_ok = act_ok[cmd_bank] && rrd_ok;
      OP_RD, OP_WR:   tim_ok = col_ok[cmd_bank] && col_free;
      OP_PRE:         tim_ok = pre_ok[cmd_bank];
      OP_PREA:        tim_ok = &pre_ok;
      OP_MRS, OP_REF: tim_ok = &idle;
      default:        tim_ok = 1'b1;
    endcase
    tim_ok = tim_ok && quiet_ok;
  end

  assign issue      = cmd_valid && legal && tim_ok;
  assign cmd_ready  = !legal || tim_ok;
  assign cmd_reject = cmd_valid && !legal;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_act[b] = issue && (op == OP_ACT) && (cmd_bank == BAW'(b));
    assign bank_col[b] = issue && is_col && (cmd_bank == BAW'(b));
    assign bank_pre[b] = issue && ((op == OP_PREA) ||
                                   ((op == OP_PRE) && (cmd_bank == BAW'(b))));
    sdc_bank_ctl #(
      .RCD(RCD_C), .RAS(RAS_C), .RC(RC_C), .RP(RP_C),
      .BL(BURST_LEN), .WR(WR_CK), .CW(CW)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (bank_act[b]),
      .col_i    (bank_col[b]),
      .col_wr_i (op == OP_WR),
      .col_ap_i (cmd_addr[AP_BIT]),
      .pre_i    (bank_pre[b]),
      .open_o   (is_open[b]),
      .closing_o(closing[b]),
      .act_ok_o (act_ok[b]),
      .col_ok_o (col_ok[b]),
      .pre_ok_o (pre_ok[b]),
      .idle_o   (idle[b])
    );
  end

  sdc_dev_ctl #(
    .RRD(RRD_C), .MRD(MRD_CK), .RFC(RC_C), .BL(BURST_LEN), .CW(CW)
  ) u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (issue),
    .act_i     (issue && op == OP_ACT),
    .col_i     (issue && is_col),
    .col_ap_i  (cmd_addr[AP_BIT]),
    .mrs_i     (issue && op == OP_MRS),
    .ref_i     (issue && op == OP_REF),
    .rrd_ok_o  (rrd_ok),
    .col_free_o(col_free),
    .quiet_ok_o(quiet_ok)
  );

  sdc_pin_drv #(
    .AW(AW), .COLW(COLW), .AP_BIT(AP_BIT), .BAW(BAW)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue_i(issue),
    .op_i   (op),
    .bank_i (cmd_bank),
    .addr_i (cmd_addr),
    .pins_o (pins),
    .ba_o   (sd_ba),
    .addr_o (sd_addr)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

  AST_STALL_DRIVES_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111)); // R1
  AST_REJECT_DRIVES_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111)); // R9
  AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_PREA) |=> (is_open == '0)); // R10
  AST_REFRESH_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == OP_REF || op == OP_MRS)) |-> (is_open == '0)); // R8

endmodule

// File: tb/sim_sdc_cmd_timer.sv
module sim_sdc_cmd_timer;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] C_MRS = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PREA = 3'd5, C_REF = 3'd6, C_BST = 3'd7;
  localparam int P_MRS = 0, P_REF = 1, P_ACT = 3, P_RD = 5, P_WR = 4,
                 P_PRE = 2, P_BST = 6, P_NOP = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c_valid = 1'b0;
  logic [2:0]  c_op = '0;
  logic [1:0]  c_bank = '0;
  logic [12:0] c_addr = '0;
  logic        cmd_ready, cmd_reject;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  wire  [3:0]  pins_w = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  sdc_cmd_timer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c_valid), .cmd_op(c_op),
    .cmd_bank(c_bank), .cmd_addr(c_addr), .cmd_ready(cmd_ready),
    .cmd_reject(cmd_reject), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Offer a command from a falling edge; return the edge that took it.
  task automatic send(input logic [2:0] op, input logic [1:0] b,
                      input logic [12:0] a, output int at, output bit rej);
    int waited = 0;
    c_valid = 1'b1; c_op = op; c_bank = b; c_addr = a;
    #1;
    while (!cmd_ready && waited < 200) begin
      @(negedge clk); #1;
      waited++;
    end
    if (waited >= 200) chk("send stuck", 0, 1);
    rej = cmd_reject;
    at  = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    c_valid = 1'b0;
  endtask

  task automatic close_all();
    int t; bit r;
    send(C_PREA, 2'd0, 13'd0, t, r);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 pins no-op after reset", pins_w, P_NOP);
    chk("R11 ready after reset", cmd_ready, 1);
    chk("R11 no reject after reset", cmd_reject, 0);
  endtask

  task automatic t_act_then_read();
    int a; bit r;
    send(C_ACT, 2'd1, 13'h1ABC, a, r);
    chk("R1 activate code", pins_w, P_ACT);
    chk("R2 activate bank", sd_ba, 1);
    chk("R2 activate row", sd_addr, 13'h1ABC);
    c_valid = 1'b1; c_op = C_RD; c_bank = 2'd1; c_addr = 13'h1BF5;
    #1 chk("R3 read held one clock after activate", cmd_ready, 0);
    @(negedge clk); #1;
    chk("R1 no-op on stalled cycle", pins_w, P_NOP);
    chk("R3 read ready at RCD", cmd_ready, 1);
    @(posedge clk); @(negedge clk);
    c_valid = 1'b0;
    chk("R1 read code", pins_w, P_RD);
    chk("R2 column with high bits cleared", sd_addr, 13'h3F5);
    close_all();
  endtask

  task automatic t_act_spacing();
    int a, b, p, c; bit r;
    send(C_ACT, 2'd0, 13'h0010, a, r);
    send(C_ACT, 2'd3, 13'h0020, b, r);
    chk("R4 activate to other bank gap", b - a, 2);
    send(C_PRE, 2'd0, 13'h1FFF, p, r);
    chk("R5 precharge after row-active time", p - a, 5);
    chk("R2 precharge address zero", sd_addr, 0);
    send(C_ACT, 2'd0, 13'h0011, c, r);
    chk("R4 same-bank activate after row cycle", c - a, 7);
    chk("R5 activate after precharge recovery", c - p, 2);
    close_all();
  endtask

  task automatic t_write_recovery();
    int a, w, p; bit r;
    send(C_ACT, 2'd2, 13'h0100, a, r);
    send(C_WR, 2'd2, 13'h0012, w, r);
    chk("R1 write code", pins_w, P_WR);
    chk("R2 write column", sd_addr, 13'h012);
    send(C_PRE, 2'd2, 13'h0, p, r);
    chk("R6 precharge after write recovery", p - w, 5);
    close_all();
  endtask

  task automatic t_ap_read();
    int a, b, rd, rd2, c; bit r;
    send(C_ACT, 2'd0, 13'h0005, a, r);
    send(C_ACT, 2'd2, 13'h0006, b, r);
    send(C_RD, 2'd0, 13'h0455, rd, r);
    chk("R2 auto-precharge bit on read", sd_addr, 13'h455);
    send(C_RD, 2'd2, 13'h0001, rd2, r);
    chk("R7 column held during auto-precharge burst", rd2 - rd, 4);
    send(C_ACT, 2'd0, 13'h0007, c, r);
    chk("R7 reopen after read auto-precharge", c - rd, 6);
    close_all();
  endtask

  task automatic t_ap_write();
    int a, w, x, c; bit r;
    send(C_ACT, 2'd1, 13'h0033, a, r);
    send(C_WR, 2'd1, 13'h0401, w, r);
    send(C_RD, 2'd1, 13'h0002, x, r);
    chk("R9 read to self-closing bank refused", r, 1);
    chk("R9 refused read leaves pins idle", pins_w, P_NOP);
    send(C_ACT, 2'd1, 13'h0034, c, r);
    chk("R7 reopen after write auto-precharge", c - w, 7);
    close_all();
  endtask

  task automatic t_reject();
    int t; bit r;
    send(C_ACT, 2'd3, 13'h0044, t, r);
    send(C_RD, 2'd0, 13'h0001, t, r);
    chk("R9 read to closed bank refused", r, 1);
    chk("R9 pins idle after refusal", pins_w, P_NOP);
    send(C_ACT, 2'd3, 13'h0045, t, r);
    chk("R9 activate to open bank refused", r, 1);
    send(C_MRS, 2'd0, 13'h0032, t, r);
    chk("R9 mode set with open row refused", r, 1);
    chk("R9 pins idle after mode set refusal", pins_w, P_NOP);
    close_all();
  endtask

  task automatic t_prea_mrs();
    int a, b, p, m, c; bit r;
    send(C_ACT, 2'd0, 13'h0001, a, r);
    send(C_ACT, 2'd1, 13'h0002, b, r);
    send(C_PREA, 2'd2, 13'h0000, p, r);
    chk("R10 precharge-all waits for last row time", p - a, 7);
    chk("R1 precharge-all code", pins_w, P_PRE);
    chk("R2 precharge-all bit", sd_addr, 13'h400);
    send(C_MRS, 2'd2, 13'h0032, m, r);
    chk("R10 all banks closed so mode set taken", r, 0);
    chk("R8 mode set after precharge recovery", m - p, 2);
    chk("R1 mode set code", pins_w, P_MRS);
    chk("R2 mode word and bank", {sd_ba, sd_addr}, {2'd2, 13'h0032});
    send(C_ACT, 2'd3, 13'h0009, c, r);
    chk("R8 command after mode set gap", c - m, 2);
    close_all();
  endtask

  task automatic t_refresh();
    int f, c, s; bit r;
    send(C_REF, 2'd0, 13'h0, f, r);
    chk("R1 refresh code", pins_w, P_REF);
    send(C_ACT, 2'd0, 13'h0003, c, r);
    chk("R8 command after refresh gap", c - f, 7);
    send(C_BST, 2'd0, 13'h0, s, r);
    chk("R1 burst stop immediate", s - c, 1);
    chk("R1 burst stop code", pins_w, P_BST);
    close_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_act_then_read();
    t_act_spacing();
    t_write_recovery();
    t_ap_read();
    t_ap_write();
    t_reject();
    t_prea_mrs();
    t_refresh();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule